// File: doc/BRIEF.md
# MSI Snoopy Coherence Controller

This block is the coherence engine of one private, direct-mapped cache in a bus-based multiprocessor. Each line of the cache carries a tag, one data word and a three-valued coherence state: Invalid, Shared (read-only copy) or Modified (the only copy, writable, newer than memory). Processor loads and stores arrive one at a time on a request port. Hits are served in the request cycle. Misses, and stores to read-only copies, become messages on a shared broadcast bus. Three kinds of message exist: read miss, write miss and write back. Stores that find a Shared copy send a full write miss; no separate upgrade message exists.

The same controller watches every message the other caches place on the bus. A remote miss that names a line this cache holds Modified forces the line out on the flush port one cycle later. The flush also tells memory to drop its own reply, because the cache supplies the data. A remote write miss removes the local copy. A remote read miss demotes a Modified copy to Shared. The bus is atomic and arbitration lives outside the block. A grant never coincides with a snooped message, and no snooped message arrives between the grant of a miss and its fill.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_rdy`, `bus_req`, `snp_flush` are low with `bus_cmd` = 0 (idle).
- R2: A load whose line is Invalid or holds another tag requests the bus with `bus_cmd` = 1 (read miss) at the full load address, returns `fill_data` with `cpu_rdy`, and leaves the line Shared. The index is the low `INDEX_W` address bits and the tag is the rest.
- R3: A store whose line is Invalid issues `bus_cmd` = 2 (write miss), then keeps the store data with the line Modified.
- R4: A store that finds its line Shared issues a write miss (`bus_cmd` = 2), not any upgrade code, and leaves the line Modified.
- R5: A miss that evicts a Modified line first wins the bus with `bus_cmd` = 3 (write back), carrying the victim's tag and index and its data on `bus_data`. The next request it makes is the new read miss or write miss.
- R6: Loads to Shared or Modified lines and stores to Modified lines complete without any bus request.
- R7: A snooped read miss (`snp_cmd` = 1) whose tag matches a Modified line raises `snp_flush` in the next cycle, with that address and the line data, and leaves the line Shared.
- R8: A snooped write miss (`snp_cmd` = 2) with matching tag invalidates the line. If the line was Modified it also flushes it in the next cycle; if it was Shared it does not.
- R9: A snooped message whose tag differs from the stored one, or any snooped write back (`snp_cmd` = 3), changes no line and causes no flush.
- R10: When a snooped message names the same index as a pending processor request in the same cycle, the snoop is applied first and `cpu_rdy` stays low in that cycle.
- R11: Only one processor request is outstanding: `cpu_rdy` is high only with `cpu_req`. `bus_req` stays high until `bus_gnt` arrives, and `bus_cmd` is 0 whenever `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdy | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_rdy` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant; the message on the bus outputs is taken in this cycle |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write back |
| bus_addr | output | ADDR_W | Address of the message |
| bus_data | output | DATA_W | Write-back data (0 for misses) |
| fill_vld | input | 1 | Fill data for the granted miss is present |
| fill_data | input | DATA_W | Fill data |
| snp_vld | input | 1 | A message from another cache is on the bus |
| snp_cmd | input | 2 | Snooped message kind, same codes as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | Supplying a Modified line; memory must abort its reply |
| snp_flush_addr | output | ADDR_W | Address of the flushed line |
| snp_flush_data | output | DATA_W | Data of the flushed line |

## Verification
The bench builds the block with 8-bit addresses, 16-bit data and a two-bit index, so the cache has four lines. With only four lines, two addresses 4 apart land on the same index with different tags. Each kind of eviction, clean or dirty, and on a load or on a store, can therefore be forced in a few requests. The same small index makes it easy to snoop a resident index under a foreign tag and to collide a snoop with a processor request on the same line. A bench-side memory, updated by write backs and flushes, shows whether flushed or evicted data reaches the next fill.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WB     = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WB   = 2'd1,
        FS_MISS = 2'd2,
        FS_FILL = 2'd3
    } fsm_e;

endpackage

// File: rtl/msi_snoop_eval.sv
module msi_snoop_eval
    import msi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_vld,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             upd,
    output line_st_e         new_st,
    output logic             flush
);
    logic tag_match;

    always_comb begin
        tag_match = snp_vld && (line_st != LN_I) && (line_tag == snp_tag);
        upd       = 1'b0;
        new_st    = line_st;
        flush     = 1'b0;
        if (tag_match) begin
            if (snp_cmd == BC_RDMISS && line_st == LN_M) begin
                upd    = 1'b1;
                new_st = LN_S;
                flush  = 1'b1;
            end else if (snp_cmd == BC_WRMISS) begin
                upd    = 1'b1;
                new_st = LN_I;
                flush  = (line_st == LN_M);
            end
        end
    end

endmodule

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 6,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] a_idx,
    output line_st_e           a_st,
    output logic [TAG_W-1:0]   a_tag,
    output logic [DATA_W-1:0]  a_data,
    input  logic [INDEX_W-1:0] b_idx,
    output line_st_e           b_st,
    output logic [TAG_W-1:0]   b_tag,
    output logic [DATA_W-1:0]  b_data,
    input  logic               snp_we,
    input  line_st_e           snp_st,
    input  logic               prc_we,
    input  logic [INDEX_W-1:0] prc_idx,
    input  line_st_e           prc_st,
    input  logic [TAG_W-1:0]   prc_tag,
    input  logic [DATA_W-1:0]  prc_data
);
    localparam int LINES = 1 << INDEX_W;

    typedef struct packed {
        line_st_e          st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t line_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t line_d, line_q;
        logic  sel_snp, sel_prc;

        always_comb begin
            sel_snp = snp_we && (b_idx == INDEX_W'(g));
            sel_prc = prc_we && (prc_idx == INDEX_W'(g)) && !sel_snp;
            line_d  = line_q;
            if (sel_prc) begin
                line_d.st   = prc_st;
                line_d.tag  = prc_tag;
                line_d.data = prc_data;
            end
            if (sel_snp) begin
                line_d.st = snp_st;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q <= '{st: LN_I, tag: '0, data: '0};
            end else begin
                line_q <= line_d;
            end
        end

        assign line_arr[g] = line_q;
    end

    always_comb begin
        a_st   = line_arr[a_idx].st;
        a_tag  = line_arr[a_idx].tag;
        a_data = line_arr[a_idx].data;
        b_st   = line_arr[b_idx].st;
        b_tag  = line_arr[b_idx].tag;
        b_data = line_arr[b_idx].data;
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rdy,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              fill_vld,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              snp_vld,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [ADDR_W-1:0] snp_flush_addr,
    output logic [DATA_W-1:0] snp_flush_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    typedef struct packed {
        fsm_e              fsm;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              flush;
        logic [ADDR_W-1:0] flush_addr;
        logic [DATA_W-1:0] flush_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [INDEX_W-1:0] look_idx, snp_idx;
    logic [TAG_W-1:0]   look_tag, snp_tag;
    line_st_e           a_st, b_st, snp_new_st, pw_st;
    logic [TAG_W-1:0]   a_tag, b_tag, pw_tag;
    logic [DATA_W-1:0]  a_data, b_data, pw_data;
    logic               snp_upd, snp_flush_nx, pw_en, clash, line_hit;

    assign snp_idx  = snp_addr[INDEX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:INDEX_W];
    assign look_idx = (ctl_q.fsm == FS_IDLE) ? cpu_addr[INDEX_W-1:0] : ctl_q.addr[INDEX_W-1:0];
    assign look_tag = (ctl_q.fsm == FS_IDLE) ? cpu_addr[ADDR_W-1:INDEX_W]
                                             : ctl_q.addr[ADDR_W-1:INDEX_W];
    assign clash    = snp_vld && (snp_idx == look_idx);
    assign line_hit = (a_st != LN_I) && (a_tag == look_tag);

    msi_snoop_eval #(.TAG_W(TAG_W)) u_snoop (
        .snp_vld  (snp_vld),
        .snp_cmd  (snp_cmd),
        .snp_tag  (snp_tag),
        .line_st  (b_st),
        .line_tag (b_tag),
        .upd      (snp_upd),
        .new_st   (snp_new_st),
        .flush    (snp_flush_nx)
    );

    msi_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (look_idx),
        .a_st     (a_st),
        .a_tag    (a_tag),
        .a_data   (a_data),
        .b_idx    (snp_idx),
        .b_st     (b_st),
        .b_tag    (b_tag),
        .b_data   (b_data),
        .snp_we   (snp_upd),
        .snp_st   (snp_new_st),
        .prc_we   (pw_en),
        .prc_idx  (look_idx),
        .prc_st   (pw_st),
        .prc_tag  (pw_tag),
        .prc_data (pw_data)
    );

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.flush      = snp_flush_nx;
        ctl_d.flush_addr = snp_addr;
        ctl_d.flush_data = b_data;
        cpu_rdy   = 1'b0;
        cpu_rdata = '0;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_data  = '0;
        pw_en     = 1'b0;
        pw_st     = LN_I;
        pw_tag    = a_tag;
        pw_data   = a_data;
        unique case (ctl_q.fsm)
            FS_IDLE: begin
                if (cpu_req && !clash) begin
                    ctl_d.we    = cpu_we;
                    ctl_d.addr  = cpu_addr;
                    ctl_d.wdata = cpu_wdata;
                    if (line_hit && (!cpu_we || a_st == LN_M)) begin
                        cpu_rdy   = 1'b1;
                        cpu_rdata = a_data;
                        if (cpu_we) begin
                            pw_en   = 1'b1;
                            pw_st   = LN_M;
                            pw_data = cpu_wdata;
                        end
                    end else if (!line_hit && a_st == LN_M) begin
                        ctl_d.fsm = FS_WB;
                    end else begin
                        ctl_d.fsm = FS_MISS;
                    end
                end
            end
            FS_WB, FS_MISS: begin
                bus_req = 1'b1;
                if (ctl_q.fsm == FS_WB && a_st == LN_M) begin
                    bus_cmd  = BC_WB;
                    bus_addr = {a_tag, look_idx};
                    bus_data = a_data;
                    if (bus_gnt) begin
                        pw_en     = 1'b1;
                        pw_st     = LN_I;
                        ctl_d.fsm = FS_MISS;
                    end
                end else begin
                    bus_cmd  = ctl_q.we ? BC_WRMISS : BC_RDMISS;
                    bus_addr = ctl_q.addr;
                    if (bus_gnt) begin
                        ctl_d.fsm = FS_FILL;
                    end
                end
            end
            FS_FILL: begin
                if (fill_vld) begin
                    cpu_rdy   = 1'b1;
                    cpu_rdata = fill_data;
                    pw_en     = 1'b1;
                    pw_st     = ctl_q.we ? LN_M : LN_S;
                    pw_tag    = look_tag;
                    pw_data   = ctl_q.we ? ctl_q.wdata : fill_data;
                    ctl_d.fsm = FS_IDLE;
                end
            end
            default: ctl_d.fsm = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{fsm: FS_IDLE, we: 1'b0, addr: '0, wdata: '0,
                       flush: 1'b0, flush_addr: '0, flush_data: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign snp_flush      = ctl_q.flush;
    assign snp_flush_addr = ctl_q.flush_addr;
    assign snp_flush_data = ctl_q.flush_data;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W  = 8,
    parameter int INDEX_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rdy,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic              snp_vld,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_flush,
    input logic [ADDR_W-1:0] snp_flush_addr
);

    assert_rdy_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> cpu_req);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    assert_idle_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_cmd == 2'd0));

    assert_wb_then_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd == 2'd3) |=>
            (bus_req && (bus_cmd == 2'd1 || bus_cmd == 2'd2)));

    assert_flush_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> ($past(snp_vld) && ($past(snp_cmd) == 2'd1 || $past(snp_cmd) == 2'd2)));

    assert_flush_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (snp_flush_addr == $past(snp_addr)));

    assert_wb_snoop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_vld && snp_cmd == 2'd3) |=> !snp_flush);

    assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_vld && cpu_req && snp_addr[INDEX_W-1:0] == cpu_addr[INDEX_W-1:0]) |-> !cpu_rdy);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_chk (.*);

// File: tb/msi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_rdy;
    logic [DW-1:0] cpu_rdata;
    logic bus_req, bus_gnt = 0;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic fill_vld = 0;
    logic [DW-1:0] fill_data = '0;
    logic snp_vld = 0;
    logic [1:0] snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_flush;
    logic [AW-1:0] snp_flush_addr;
    logic [DW-1:0] snp_flush_data;

    always #4 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .INDEX_W(IW), .DATA_W(DW)) u_dut (.*);

    int n_cmp = 0, n_bad = 0, bus_cnt = 0, fl_cnt = 0;
    logic [DW-1:0] mem [256];
    logic pend = 0;
    logic [AW-1:0] pend_addr = '0;
    int pend_cnt = 0;

    logic [25:0] exp_bus [$];
    string       exp_bus_rq [$];
    logic [15:0] exp_rd [$];
    string       exp_rd_rq [$];
    logic [23:0] exp_fl [$];
    string       exp_fl_rq [$];

    function automatic logic [DW-1:0] iv(int a);
        return DW'(a * 37 + 5);
    endfunction

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic xb(logic [1:0] c, logic [7:0] a, logic [15:0] d, string rq);
        exp_bus.push_back({c, a, d});
        exp_bus_rq.push_back(rq);
    endtask
    task automatic xr(logic [15:0] d, string rq);
        exp_rd.push_back(d);
        exp_rd_rq.push_back(rq);
    endtask
    task automatic xf(logic [7:0] a, logic [15:0] d, string rq);
        exp_fl.push_back({a, d});
        exp_fl_rq.push_back(rq);
    endtask

    // monitor / scoreboard and memory model
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && bus_gnt) begin
                bus_cnt++;
                if (exp_bus.size() == 0) begin
                    check("R11 unexpected bus message", {6'd0, bus_cmd, bus_addr, bus_data}, 32'hffffffff);
                end else begin
                    logic [25:0] e;
                    string rq;
                    e = exp_bus.pop_front();
                    rq = exp_bus_rq.pop_front();
                    check({rq, " bus cmd"}, 32'(bus_cmd), 32'(e[25:24]));
                    check({rq, " bus addr"}, 32'(bus_addr), 32'(e[23:16]));
                    if (e[25:24] == 2'd3) check({rq, " bus data"}, 32'(bus_data), 32'(e[15:0]));
                end
                if (bus_cmd == 2'd3) mem[bus_addr] = bus_data;
                else begin
                    pend = 1;
                    pend_addr = bus_addr;
                    pend_cnt = 2;
                end
            end
            if (cpu_rdy && !cpu_we) begin
                if (exp_rd.size() == 0) check("R6 unexpected read result", 32'(cpu_rdata), 32'hffffffff);
                else check({exp_rd_rq.pop_front(), " read data"}, 32'(cpu_rdata), 32'(exp_rd.pop_front()));
            end
            if (snp_flush) begin
                fl_cnt++;
                if (exp_fl.size() == 0) begin
                    check("R9 unexpected flush", 32'(snp_flush_addr), 32'hffffffff);
                end else begin
                    logic [23:0] f;
                    string rq;
                    f = exp_fl.pop_front();
                    rq = exp_fl_rq.pop_front();
                    check({rq, " flush addr"}, 32'(snp_flush_addr), 32'(f[23:16]));
                    check({rq, " flush data"}, 32'(snp_flush_data), 32'(f[15:0]));
                end
                mem[snp_flush_addr] = snp_flush_data;
            end
        end
    end

    // bus grant and fill responder
    always @(posedge clk) begin
        #1;
        bus_gnt = bus_req && !bus_gnt && !pend && !fill_vld;
        if (fill_vld) fill_vld = 0;
        else if (pend) begin
            if (pend_cnt == 0) begin
                fill_vld = 1;
                fill_data = mem[pend_addr];
                pend = 0;
            end else pend_cnt--;
        end
    end

    task automatic cpu_op(bit we, logic [7:0] a, logic [15:0] d);
        @(posedge clk); #1;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do @(negedge clk); while (!cpu_rdy);
        @(posedge clk); #1;
        cpu_req = 0;
    endtask

    task automatic quiet_op(bit we, logic [7:0] a, logic [15:0] d, string rq);
        int b0, f0;
        b0 = bus_cnt; f0 = fl_cnt;
        cpu_op(we, a, d);
        check({rq, " no bus traffic"}, 32'(bus_cnt), 32'(b0));
        check({rq, " no flush"}, 32'(fl_cnt), 32'(f0));
    endtask

    task automatic snoop(logic [1:0] c, logic [7:0] a);
        @(posedge clk); #1;
        snp_vld = 1; snp_cmd = c; snp_addr = a;
        @(posedge clk); #1;
        snp_vld = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int f0;
        for (int i = 0; i < 256; i++) mem[i] = iv(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 cpu_rdy", 32'(cpu_rdy), 0);
        check("R1 bus_req", 32'(bus_req), 0);
        check("R1 bus_cmd", 32'(bus_cmd), 0);
        check("R1 snp_flush", 32'(snp_flush), 0);

        // R2 read miss into Invalid line
        xb(2'd1, 8'h10, 0, "R2"); xr(iv(8'h10), "R2");
        cpu_op(0, 8'h10, 0);
        // R6 read hit in Shared
        xr(iv(8'h10), "R6");
        quiet_op(0, 8'h10, 0, "R6 read hit S");
        // R4 write to Shared: full write miss
        xb(2'd2, 8'h10, 0, "R4");
        cpu_op(1, 8'h10, 16'hAAAA);
        // R6 write hit in Modified, read hit in Modified
        quiet_op(1, 8'h10, 16'hBBBB, "R6 write hit M");
        xr(16'hBBBB, "R6");
        quiet_op(0, 8'h10, 0, "R6 read hit M");
        // R5 dirty victim on read miss
        xb(2'd3, 8'h10, 16'hBBBB, "R5"); xb(2'd1, 8'h14, 0, "R5"); xr(iv(8'h14), "R5");
        cpu_op(0, 8'h14, 0);
        // clean victim: no write back, data comes from written-back memory
        xb(2'd1, 8'h10, 0, "R5"); xr(16'hBBBB, "R5");
        cpu_op(0, 8'h10, 0);
        // R3 write to Invalid
        xb(2'd2, 8'h21, 0, "R3");
        cpu_op(1, 8'h21, 16'h1111);
        xr(16'h1111, "R3");
        quiet_op(0, 8'h21, 0, "R3 stored data");
        // R7 snooped read miss on Modified
        xf(8'h21, 16'h1111, "R7");
        snoop(2'd1, 8'h21);
        xr(16'h1111, "R7");
        quiet_op(0, 8'h21, 0, "R7 still readable");
        xb(2'd2, 8'h21, 0, "R7 line is Shared");
        cpu_op(1, 8'h21, 16'h2222);
        // R8 snooped write miss on Modified
        xf(8'h21, 16'h2222, "R8");
        snoop(2'd2, 8'h21);
        xb(2'd1, 8'h21, 0, "R8 line invalid"); xr(16'h2222, "R8");
        cpu_op(0, 8'h21, 0);
        // R8 snooped write miss on Shared: no flush
        f0 = fl_cnt;
        snoop(2'd2, 8'h10);
        check("R8 no flush from Shared", 32'(fl_cnt), 32'(f0));
        xb(2'd1, 8'h10, 0, "R8 line invalid"); xr(16'hBBBB, "R8");
        cpu_op(0, 8'h10, 0);
        // R9 tag mismatch and snooped write back
        xb(2'd2, 8'h32, 0, "R9 setup");
        cpu_op(1, 8'h32, 16'h3333);
        f0 = fl_cnt;
        snoop(2'd1, 8'h36);
        check("R9 mismatch no flush", 32'(fl_cnt), 32'(f0));
        quiet_op(1, 8'h32, 16'h4444, "R9 still Modified");
        snoop(2'd3, 8'h32);
        check("R9 write back snoop no flush", 32'(fl_cnt), 32'(f0));
        quiet_op(1, 8'h32, 16'h5555, "R9 still Modified");
        // R10 snoop and processor on same line, same cycle
        xf(8'h32, 16'h5555, "R10"); xb(2'd1, 8'h32, 0, "R10"); xr(16'h5555, "R10");
        @(posedge clk); #1;
        cpu_req = 1; cpu_we = 0; cpu_addr = 8'h32;
        snp_vld = 1; snp_cmd = 2'd2; snp_addr = 8'h32;
        @(negedge clk);
        check("R10 cpu_rdy held low", 32'(cpu_rdy), 0);
        @(posedge clk); #1;
        snp_vld = 0;
        do @(negedge clk); while (!cpu_rdy);
        @(posedge clk); #1;
        cpu_req = 0;
        // R5 dirty victim on write miss
        xb(2'd2, 8'h03, 0, "R5 setup");
        cpu_op(1, 8'h03, 16'h6666);
        xb(2'd3, 8'h03, 16'h6666, "R5"); xb(2'd2, 8'h07, 0, "R5");
        cpu_op(1, 8'h07, 16'h7777);
        xr(16'h7777, "R3");
        quiet_op(0, 8'h07, 0, "R3 write miss data kept");
        xb(2'd3, 8'h07, 16'h7777, "R5"); xb(2'd1, 8'h03, 0, "R5"); xr(16'h6666, "R5");
        cpu_op(0, 8'h03, 0);

        repeat (4) @(negedge clk);
        check("R11 all bus messages seen", 32'(exp_bus.size()), 0);
        check("R11 all reads seen", 32'(exp_rd.size()), 0);
        check("R7 all flushes seen", 32'(exp_fl.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule